// File: doc/BRIEF.md
# Memory Command Readiness Monitor

This block decides when a memory that contains an internal delay-locked loop may accept read and write commands. It works entirely in a free-running reference clock domain. The memory's input clock and its loop enable pin are both sampled as data in that domain. Two separate waits must both be satisfied before the ready flag rises.

The first wait is a time-based settling interval. It is a parameterised number of reference cycles during which the input clock keeps toggling, and it is only needed once after power-on reset. The second wait is a lock interval. It is a parameterised number of input-clock rising edges counted while the enable is high, and it starts over whenever the enable drops or the input clock pauses for longer than a parameterised timeout.

A command request raised while the flag is low sets a sticky error flag. Only power-on reset clears that flag.

Top module: `dll_ready_monitor`

## Requirements
- R1: While `por_n` is low, `ready` and `cmd_err` are 0. After reset, `ready` is 1 exactly when the settling interval has completed and the lock count has reached LOCK_EDGES.
- R2: After `por_n` rises, `ready` stays 0 until INIT_CYCLES reference cycles have passed with the input clock running. With lock already reached, `ready` rises within a few cycles of that point.
- R3: The settling interval is paid only once per power-on reset. A later loss of lock needs only the lock interval to recover, even when that interval is shorter than INIT_CYCLES. A new `por_n` pulse requires the settling interval again.
- R4: The lock count advances on input-clock rising edges while `dll_en` is high. `ready` stays 0 until LOCK_EDGES such edges have been seen.
- R5: Driving `dll_en` low clears the lock count. `ready` falls within 4 reference cycles.
- R6: If the input clock shows no edge for STOP_TIMEOUT reference cycles, the lock count clears and `ready` falls. If the settling interval has not finished, it restarts from zero. Gaps shorter than the timeout leave `ready` high.
- R7: A `cmd_req` pulse sampled while `ready` is 0 makes `cmd_err` 1 from the next reference cycle on. A pulse while `ready` is 1 leaves `cmd_err` unchanged.
- R8: Once set, `cmd_err` stays 1 through any change of `ready`. Only `por_n` low returns it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock; all state runs on it |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| in_clk | input | 1 | Memory input clock, sampled as data |
| dll_en | input | 1 | Loop enable level, sampled as data |
| cmd_req | input | 1 | Read or write command request, synchronous to ref_clk |
| ready | output | 1 | High when commands may be issued |
| cmd_err | output | 1 | Sticky flag: a command was requested while not ready |

## Verification
The assertions assume that the input clock toggles no faster than once every two reference cycles, so the synchronizer sees every edge. They also assume that `cmd_req` is synchronous to the reference clock and that `por_n` is low from time zero. The bench produces the input clock by toggling it every second reference cycle, on the falling reference edge. It drives every other input on that same falling edge. Stops and short pauses are made only by holding the toggle back. The randomised parts vary only the enable-low length and the spacing of command pulses, and both stay inside these limits.

// File: rtl/rdymon_pkg.sv
package rdymon_pkg;

   typedef enum logic {
      ACT_ANY_EDGE  = 1'b0,
      ACT_RISE_ONLY = 1'b1
   } act_mode_e;

   function automatic int unsigned cnt_width(input int unsigned maxv);
      return (maxv < 1) ? 1 : $clog2(maxv + 1);
   endfunction

endpackage

// File: rtl/rdymon_sync.sv
module rdymon_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rdymon_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rdymon_activity.sv
module rdymon_activity #(
   parameter int unsigned          STOP_TIMEOUT = 6,
   parameter rdymon_pkg::act_mode_e MODE        = rdymon_pkg::ACT_ANY_EDGE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clk_lvl,
   output logic rise,
   output logic stopped
);
   import rdymon_pkg::*;

   localparam int unsigned GW = cnt_width(STOP_TIMEOUT);
   localparam logic [GW-1:0] GAP_MAX = GW'(STOP_TIMEOUT);

   if (STOP_TIMEOUT < 2) begin : g_bad_timeout
      $error("rdymon_activity: STOP_TIMEOUT must be at least 2");
   end

   logic          prev_lvl;
   logic          alive;
   logic [GW-1:0] gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_lvl <= 1'b0;
      else        prev_lvl <= clk_lvl;
   end

   assign rise = clk_lvl & ~prev_lvl;

   if (MODE == ACT_RISE_ONLY) begin : g_rise_only
      assign alive = rise;
   end else begin : g_any_edge
      logic fall;
      assign fall  = ~clk_lvl & prev_lvl;
      assign alive = rise | fall;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              gap <= '0;
      else if (alive)          gap <= '0;
      else if (gap != GAP_MAX) gap <= gap + 1'b1;
   end

   assign stopped = (gap == GAP_MAX);

   assert_edge_revives_R6: assert property (@(posedge clk) disable iff (!rst_n)
      alive |=> !stopped);
   assert_gap_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
      gap <= GAP_MAX);
endmodule

// File: rtl/rdymon_init_timer.sv
module rdymon_init_timer #(
   parameter int unsigned INIT_CYCLES = 4000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stopped,
   output logic done
);
   import rdymon_pkg::*;

   localparam int unsigned IW = cnt_width(INIT_CYCLES);
   localparam logic [IW-1:0] LAST = IW'(INIT_CYCLES - 1);

   if (INIT_CYCLES < 1) begin : g_bad_init
      $error("rdymon_init_timer: INIT_CYCLES must be at least 1");
   end

   logic [IW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (!done) begin
         if (stopped) begin
            cnt <= '0;
         end else if (cnt == LAST) begin
            done <= 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assert_once_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);
   assert_restart_on_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stopped && !done) |=> (cnt == '0 && !done));
endmodule

// File: rtl/rdymon_lock_counter.sv
module rdymon_lock_counter #(
   parameter int unsigned LOCK_EDGES = 2048
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic stopped,
   input  logic rise,
   output logic locked
);
   import rdymon_pkg::*;

   localparam int unsigned LW = cnt_width(LOCK_EDGES);
   localparam logic [LW-1:0] LOCK_MAX = LW'(LOCK_EDGES);

   if (LOCK_EDGES < 1) begin : g_bad_lock
      $error("rdymon_lock_counter: LOCK_EDGES must be at least 1");
   end

   logic [LW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt <= '0;
      else if (!enable || stopped)       cnt <= '0;
      else if (rise && cnt != LOCK_MAX)  cnt <= cnt + 1'b1;
   end

   assign locked = (cnt == LOCK_MAX);

   assert_lock_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LOCK_MAX);
   assert_clear_on_disable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (cnt == '0));
   assert_clear_on_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      stopped |=> !locked);
endmodule

// File: rtl/dll_ready_monitor.sv
module dll_ready_monitor #(
   parameter int unsigned           INIT_CYCLES  = 4000,
   parameter int unsigned           LOCK_EDGES   = 2048,
   parameter int unsigned           STOP_TIMEOUT = 6,
   parameter int unsigned           SYNC_STAGES  = 2,
   parameter rdymon_pkg::act_mode_e ACT_MODE     = rdymon_pkg::ACT_ANY_EDGE
) (
   input  logic ref_clk,
   input  logic por_n,
   input  logic in_clk,
   input  logic dll_en,
   input  logic cmd_req,
   output logic ready,
   output logic cmd_err
);
   logic clk_lvl;
   logic en_lvl;
   logic rise;
   logic stopped;
   logic init_done;
   logic locked;

   rdymon_sync #(.STAGES(SYNC_STAGES)) u_clk_sync (
      .clk(ref_clk), .rst_n(por_n), .d(in_clk), .q(clk_lvl));

   rdymon_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
      .clk(ref_clk), .rst_n(por_n), .d(dll_en), .q(en_lvl));

   rdymon_activity #(.STOP_TIMEOUT(STOP_TIMEOUT), .MODE(ACT_MODE)) u_activity (
      .clk(ref_clk), .rst_n(por_n), .clk_lvl(clk_lvl),
      .rise(rise), .stopped(stopped));

   rdymon_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_init (
      .clk(ref_clk), .rst_n(por_n), .stopped(stopped), .done(init_done));

   rdymon_lock_counter #(.LOCK_EDGES(LOCK_EDGES)) u_lock (
      .clk(ref_clk), .rst_n(por_n), .enable(en_lvl), .stopped(stopped),
      .rise(rise), .locked(locked));

   assign ready = init_done & locked;

   always_ff @(posedge ref_clk or negedge por_n) begin
      if (!por_n)                  cmd_err <= 1'b0;
      else if (cmd_req && !ready)  cmd_err <= 1'b1;
   end

   assert_err_on_early_cmd_R7: assert property (@(posedge ref_clk) disable iff (!por_n)
      (cmd_req && !ready) |=> cmd_err);
   assert_err_sticky_R8: assert property (@(posedge ref_clk) disable iff (!por_n)
      cmd_err |=> cmd_err);
   assert_no_spurious_err_R7: assert property (@(posedge ref_clk) disable iff (!por_n)
      (!cmd_err && !cmd_req) |=> !cmd_err);
   assert_ready_needs_lock_R1: assert property (@(posedge ref_clk) disable iff (!por_n)
      $rose(ready) |-> en_lvl);
endmodule

// File: tb/dll_ready_monitor_tb.sv
module dll_ready_monitor_tb;
   localparam int INIT = 400;
   localparam int LOCK = 64;
   localparam int TOUT = 6;
   localparam int LOCK_T = LOCK * 4;

   logic ref_clk = 1'b0;
   logic por_n   = 1'b0;
   logic in_clk  = 1'b0;
   logic dll_en  = 1'b1;
   logic cmd_req = 1'b0;
   logic ready, cmd_err;

   int checks = 0;
   int failures = 0;
   bit in_run = 1'b1;
   int pause_left = 0;
   int ph = 0;

   always #2.5 ref_clk = ~ref_clk;

   dll_ready_monitor #(.INIT_CYCLES(INIT), .LOCK_EDGES(LOCK), .STOP_TIMEOUT(TOUT)) u_dut (
      .ref_clk(ref_clk), .por_n(por_n), .in_clk(in_clk), .dll_en(dll_en),
      .cmd_req(cmd_req), .ready(ready), .cmd_err(cmd_err));

   always @(negedge ref_clk) begin
      if (in_run) begin
         if (pause_left > 0) pause_left = pause_left - 1;
         else begin
            ph = ph + 1;
            if (ph >= 2) begin ph = 0; in_clk = ~in_clk; end
         end
      end
   end

   function automatic logic exp_err(input logic prev_err, input logic req, input logic rdy);
      return prev_err | (req & ~rdy);
   endfunction

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge ref_clk);
   endtask

   task automatic por_pulse();
      por_n = 1'b0;
      wait_n(3);
      por_n = 1'b1;
   endtask

   task automatic cmd_pulse();
      logic before_err, before_rdy;
      before_err = cmd_err;
      before_rdy = ready;
      cmd_req = 1'b1;
      wait_n(1);
      cmd_req = 1'b0;
      chk("R7 cmd_err after request", cmd_err, exp_err(before_err, 1'b1, before_rdy));
   endtask

   task automatic relock_window(input string req);
      wait_n(LOCK_T - 16);
      chk({req, " ready low inside lock wait"}, ready, 1'b0);
      wait_n(40);
      chk({req, " ready high after lock wait"}, ready, 1'b1);
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge ref_clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
   end

   initial begin
      int unsigned seed;
      seed = 32'd7743;
      void'($urandom(seed));

      wait_n(10);
      chk("R1 reset ready", ready, 1'b0);
      chk("R8 reset cmd_err", cmd_err, 1'b0);

      // Power-up: lock finishes first, settling governs ready (R1, R2)
      por_n = 1'b1;
      wait_n(5);
      cmd_pulse();
      wait_n(389);
      chk("R2 ready low before settling", ready, 1'b0);
      wait_n(20);
      chk("R1 ready high after settling and lock", ready, 1'b1);
      chk("R8 cmd_err kept while ready", cmd_err, 1'b1);

      // New power-on reset clears error and reapplies settling (R8, R3)
      por_pulse();
      chk("R8 cmd_err cleared by por", cmd_err, 1'b0);
      wait_n(390);
      chk("R3 settling required again after por", ready, 1'b0);
      wait_n(30);
      chk("R3 ready after second settling", ready, 1'b1);

      // Random commands while ready: no effect (R7)
      for (int i = 0; i < 20; i++) begin
         wait_n(1 + ($urandom % 8));
         cmd_pulse();
      end
      chk("R7 cmd_err untouched while ready", cmd_err, 1'b0);

      // Random enable-low periods: quick drop, relock only (R5, R4, R3)
      for (int i = 0; i < 4; i++) begin
         int low_len;
         low_len = 5 + int'($urandom % 26);
         dll_en = 1'b0;
         wait_n(4);
         chk("R5 ready falls after enable low", ready, 1'b0);
         wait_n(low_len - 4);
         dll_en = 1'b1;
         relock_window("R4 R3 relock");
      end

      // Short pause below timeout keeps ready (R6)
      pause_left = 2;
      for (int i = 0; i < 30; i++) begin
         wait_n(1);
         if (ready !== 1'b1) begin
            chk("R6 short pause keeps ready", ready, 1'b1);
            break;
         end
      end
      chk("R6 ready after short pause", ready, 1'b1);

      // Long stop clears lock (R6)
      in_run = 1'b0;
      wait_n(20);
      chk("R6 ready falls on clock stop", ready, 1'b0);
      in_run = 1'b1;
      relock_window("R6 after stop");

      // Stop during settling restarts it (R6, R2)
      por_pulse();
      wait_n(200);
      in_run = 1'b0;
      wait_n(20);
      in_run = 1'b1;
      wait_n(380);
      chk("R6 settling restarted after stop", ready, 1'b0);
      wait_n(40);
      chk("R2 ready after restarted settling", ready, 1'b1);

      // Enable low through power-up: settling alone is not enough (R4, R1)
      dll_en = 1'b0;
      por_pulse();
      wait_n(600);
      chk("R4 ready low without enable", ready, 1'b0);
      cmd_pulse();
      dll_en = 1'b1;
      relock_window("R4 lock after late enable");
      chk("R8 cmd_err stays set after ready rises", cmd_err, 1'b1);
      wait_n(10);
      cmd_pulse();
      chk("R8 cmd_err still set", cmd_err, 1'b1);

      report();
   end
endmodule